// File: doc/BRIEF.md
# Fractional Code Dithering Modulator

This block turns a fixed-point oscillator control word into a stream of whole integer codes whose long-run average equals the fractional value of the word. The input has 25 bits: the upper 10 are the integer code and the lower 15 are a fraction of one code step. Each output code is either the integer part or a code near it, chosen so that the time average matches the full input. This gives an oscillator that only accepts whole codes a much finer effective frequency step. The block runs on the fast digital clock of the loop and drives the oscillator code path.

Two noise-shaping orders are available and can be changed while the block runs. In first order, one 15-bit error accumulator adds the fraction every cycle and its carry is added to the integer code. In second order, a second 15-bit accumulator integrates the residue of the first. The output becomes the integer code plus the first carry plus the second carry minus the second carry of the previous cycle, which gives a noise transfer of (1 - z^-1)^2. Every output is registered, so the signal path has one cycle of delay. Any change of order clears both accumulators so the new mode starts from a known state. The result is clamped to the 10-bit range so a code at an edge cannot wrap.

Top module: `frac_dither_mod`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, `code_out` is 0, and both accumulators are 0 with first order recorded as the active order.
- R2: The output is registered: an input applied before a rising clock edge shows up on `code_out` after that edge and not before.
- R3: With `order_sel` = 0 (first order) held, each cycle the 15-bit fraction is added to the first accumulator modulo 2^15, and `code_out` equals the integer part (bits 24:15) plus the carry out of that addition.
- R4: In first order with a constant input, starting from cleared accumulators, the sum of the codes over 2^15 cycles is exactly 2^15 times the integer part plus the fraction (bits 14:0).
- R5: With `order_sel` = 1 (second order) held, the second 15-bit accumulator adds the new residue of the first one each cycle, and `code_out` equals integer part + first carry + second carry - the second carry of the previous cycle.
- R6: In second order with a constant input away from the range edges, starting from cleared accumulators, the sum of the codes over 2^15 cycles differs from 2^15 times the integer part plus the fraction by at most 1.
- R7: `order_sel` is sampled every cycle: 0 selects first order and 1 selects second order. In first order the second accumulator and the stored second carry stay at 0.
- R8: In a cycle where `order_sel` differs from the active order, both accumulators and the stored second carry are cleared, the new order becomes active, and the code output on the next edge is the plain integer part.
- R9: The code is clamped to the range 0 to 1023: a result above 1023 gives 1023 and a result below 0 gives 0.
- R10: In first order with a fraction of 0, the output equals the integer part in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast digital loop clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 25 | Control word: bits 24:15 integer code, bits 14:0 fraction |
| order_sel | input | 1 | Shaping order: 0 first, 1 second |
| code_out | output | 10 | Dithered integer oscillator code |

## Verification
The hard cases are those where two functions act in the same cycle: an order switch landing on a cycle whose accumulators would otherwise carry, and the second-order combination that gives a value below 0 or above 1023 and so must be clamped at the same edge. The bench creates the first case by flipping `order_sel` at random times during random traffic, while the accumulators hold nonzero residues, and expects the plain integer part on the switch cycle followed by a restart from zero. It creates the second case with integer parts of 0 and 1023 and large fractions in both orders. Every code is compared with a cycle model of the requirement equations, and the average is also checked against the exact sum bounds for both orders.

// File: rtl/dsm_types_pkg.sv
package dsm_types_pkg;

    // Default word geometry of the oscillator control path
    localparam int DEF_INT_W  = 10;
    localparam int DEF_FRAC_W = 15;

    // Highest supported shaping order, one accumulator per order
    localparam int MAX_ORDER  = 2;

    typedef enum logic {
        ORD_FIRST  = 1'b0,
        ORD_SECOND = 1'b1
    } order_e;

endpackage

// File: rtl/dsm_residue_stage.sv
// One error-feedback accumulation: residue plus addend, with carry out.
module dsm_residue_stage #(
    parameter int W = 15
) (
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] addend,
    output logic [W-1:0] residue,
    output logic         carry
);

    logic [W:0] total;

    always_comb begin
        total   = {1'b0, acc_in} + {1'b0, addend};
        residue = total[W-1:0];
        carry   = total[W];
    end

endmodule

// File: rtl/dsm_code_merge.sv
// Combines the integer part with the stage carries and clamps the result.
module dsm_code_merge #(
    parameter int INT_W = 10
) (
    input  logic [INT_W-1:0] int_part,
    input  logic             carry_a,
    input  logic             carry_b,
    input  logic             carry_b_prev,
    input  logic             use_second,
    output logic [INT_W-1:0] code
);

    localparam int SW = INT_W + 2;
    localparam logic signed [SW-1:0] CODE_MAX = SW'((1 << INT_W) - 1);

    logic signed [SW-1:0] base;
    logic signed [SW-1:0] adj;
    logic signed [SW-1:0] total;

    always_comb begin
        base = $signed({2'b00, int_part});
        adj  = $signed({{(SW-1){1'b0}}, carry_a});
        if (use_second) begin
            adj = adj + $signed({{(SW-1){1'b0}}, carry_b})
                      - $signed({{(SW-1){1'b0}}, carry_b_prev});
        end
        total = base + adj;
        if (total < 0) begin
            code = '0;
        end else if (total > CODE_MAX) begin
            code = CODE_MAX[INT_W-1:0];
        end else begin
            code = total[INT_W-1:0];
        end
    end

endmodule

// File: rtl/frac_dither_mod.sv
module frac_dither_mod
    import dsm_types_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INT_W+FRAC_W-1:0] ctrl_word,
    input  logic                    order_sel,
    output logic [INT_W-1:0]        code_out
);

    localparam int STAGES = MAX_ORDER;
    localparam int WORD_W = INT_W + FRAC_W;

    typedef struct packed {
        logic [STAGES-1:0][FRAC_W-1:0] acc;
        logic                          carry_b_prev;
        order_e                        order;
        logic [INT_W-1:0]              code;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    order_e            req_order;
    logic              order_change;

    logic [FRAC_W-1:0] stg_in    [STAGES];
    logic [FRAC_W-1:0] stg_res   [STAGES];
    logic              stg_carry [STAGES];

    logic [INT_W-1:0]  merged_code;
    logic [FRAC_W-1:0] res1_q;
    logic [FRAC_W-1:0] res2_q;
    logic              order_q;

    assign int_part  = ctrl_word[WORD_W-1:FRAC_W];
    assign frac_part = ctrl_word[FRAC_W-1:0];
    assign req_order = order_e'(order_sel);

    // Cascade of error accumulators: stage 0 takes the fraction,
    // every later stage takes the new residue of the stage before it.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign stg_in[i] = frac_part;
            end else begin : g_tail
                assign stg_in[i] = stg_res[i-1];
            end
            dsm_residue_stage #(
                .W(FRAC_W)
            ) u_stage (
                .acc_in (st_q.acc[i]),
                .addend (stg_in[i]),
                .residue(stg_res[i]),
                .carry  (stg_carry[i])
            );
        end
    endgenerate

    dsm_code_merge #(
        .INT_W(INT_W)
    ) u_merge (
        .int_part    (int_part),
        .carry_a     (stg_carry[0]),
        .carry_b     (stg_carry[1]),
        .carry_b_prev(st_q.carry_b_prev),
        .use_second  (st_q.order == ORD_SECOND),
        .code        (merged_code)
    );

    always_comb begin
        st_d         = st_q;
        order_change = (req_order != st_q.order);
        if (order_change) begin
            st_d.acc          = '0;
            st_d.carry_b_prev = 1'b0;
            st_d.order        = req_order;
            st_d.code         = int_part;
        end else begin
            st_d.acc[0] = stg_res[0];
            if (st_q.order == ORD_SECOND) begin
                st_d.acc[1]       = stg_res[1];
                st_d.carry_b_prev = stg_carry[1];
            end else begin
                st_d.acc[1]       = '0;
                st_d.carry_b_prev = 1'b0;
            end
            st_d.code = merged_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{acc: '0, carry_b_prev: 1'b0, order: ORD_FIRST, code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign code_out = st_q.code;
    assign res1_q   = st_q.acc[0];
    assign res2_q   = st_q.acc[1];
    assign order_q  = st_q.order;

endmodule

// File: rtl/dsm_checker.sv
module dsm_checker #(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 15
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [INT_W+FRAC_W-1:0] ctrl_word,
    input logic                    order_sel,
    input logic [INT_W-1:0]        code_out,
    input logic [FRAC_W-1:0]       res1_q,
    input logic [FRAC_W-1:0]       res2_q,
    input logic                    order_q
);

    localparam int WORD_W = INT_W + FRAC_W;

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1: a cycle spent in reset leaves a zero code behind it
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (code_out == '0));

    // R3: steady first order only ever adds 0 or 1 to the integer part
    a_r3_first_band: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(order_sel) == 1'b0 && $past(order_q) == 1'b0)
        |-> ({1'b0, code_out} == {1'b0, $past(ctrl_word[WORD_W-1:FRAC_W])} ||
             {1'b0, code_out} == {1'b0, $past(ctrl_word[WORD_W-1:FRAC_W])} + 1'b1));

    // R5: steady second order stays between integer-1 and integer+2
    a_r5_second_band: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(order_sel) == 1'b1 && $past(order_q) == 1'b1)
        |-> (({2'b00, code_out} + 12'd1 >= {2'b00, $past(ctrl_word[WORD_W-1:FRAC_W])}) &&
             ({2'b00, code_out} <= {2'b00, $past(ctrl_word[WORD_W-1:FRAC_W])} + 12'd2)));

    // R8: an order switch clears the residues and passes the integer part
    a_r8_switch_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(order_sel) != $past(order_q))
        |-> (res1_q == '0 && res2_q == '0 && order_q == $past(order_sel) &&
             code_out == $past(ctrl_word[WORD_W-1:FRAC_W])));

    // R7: first order keeps the second residue empty
    a_r7_second_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && order_q == 1'b0) |-> (res2_q == '0));

    // R10: zero fraction in steady first order gives the integer part
    a_r10_zero_frac: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctrl_word[FRAC_W-1:0]) == '0 &&
         $past(order_sel) == 1'b0 && $past(order_q) == 1'b0)
        |-> (code_out == $past(ctrl_word[WORD_W-1:FRAC_W])));

endmodule

bind frac_dither_mod dsm_checker #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_word(ctrl_word),
    .order_sel(order_sel),
    .code_out (code_out),
    .res1_q   (res1_q),
    .res2_q   (res2_q),
    .order_q  (order_q)
);

// File: tb/sim_frac_dither_mod.sv
`timescale 1ns/1ps
module sim_frac_dither_mod;

    localparam int INT_W  = 10;
    localparam int FRAC_W = 15;
    localparam int NAVG   = 1 << FRAC_W;
    localparam int FMASK  = (1 << FRAC_W) - 1;

    logic                    clk;
    logic                    rst_n;
    logic [INT_W+FRAC_W-1:0] ctrl_word;
    logic                    order_sel;
    logic [INT_W-1:0]        code_out;

    int n_checks;
    int n_fail;
    bit done;

    // Bench model state, built from the requirement equations
    int m_acc1, m_acc2, m_cbp, m_ord;
    int exp_code;

    frac_dither_mod #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_word(ctrl_word),
        .order_sel(order_sel),
        .code_out (code_out)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic int clamp_code(input int v);
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    task automatic model_reset();
        m_acc1 = 0; m_acc2 = 0; m_cbp = 0; m_ord = 0; exp_code = 0;
    endtask

    // One cycle of the expected behaviour (R3, R5, R7, R8, R9)
    task automatic model_step(input int ip, input int fr, input int ord);
        int s1, c1, s2, c2;
        if (ord != m_ord) begin
            m_acc1 = 0; m_acc2 = 0; m_cbp = 0; m_ord = ord;
            exp_code = ip;
        end else begin
            s1 = m_acc1 + fr;
            c1 = s1 >> FRAC_W;
            m_acc1 = s1 & FMASK;
            if (ord == 1) begin
                s2 = m_acc2 + m_acc1;
                c2 = s2 >> FRAC_W;
                m_acc2 = s2 & FMASK;
                exp_code = clamp_code(ip + c1 + c2 - m_cbp);
                m_cbp = c2;
            end else begin
                exp_code = clamp_code(ip + c1);
            end
        end
    endtask

    task automatic check(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Drive on the falling edge, let the rising edge register, sample at the next falling edge
    task automatic cycle(input int ip, input int fr, input int ord, input string tag);
        ctrl_word = {ip[INT_W-1:0], fr[FRAC_W-1:0]};
        order_sel = ord[0];
        model_step(ip, fr, ord);
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(code_out), exp_code);
    endtask

    initial begin
        int seed_sink;
        int sum;
        int ip, fr, ord;
        seed_sink = $urandom(32'd20240611);
        n_checks = 0; n_fail = 0; done = 0;
        rst_n = 1'b0; ctrl_word = '0; order_sel = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset code", int'(code_out), 0);
        ctrl_word = {10'd77, 15'd0};
        @(negedge clk);
        check("R1 held in reset", int'(code_out), 0);
        rst_n = 1'b1;
        check("R1 after release", int'(code_out), 0);

        // R2 / R10: latency and zero fraction
        ctrl_word = {10'd500, 15'd0};
        order_sel = 1'b0;
        #1;
        check("R2 not before edge", int'(code_out), 0);
        model_step(500, 0, 0);
        @(posedge clk); @(negedge clk);
        check("R2 one cycle later", int'(code_out), 500);
        for (int i = 0; i < 8; i++) cycle(500, 0, 0, "R10 zero fraction");

        // R4: first-order exact average, from cleared state via two switches
        cycle(300, 0, 1, "R8 switch to second");
        cycle(300, 0, 0, "R8 switch to first");
        sum = 0;
        for (int i = 0; i < NAVG; i++) begin
            cycle(300, 12345, 0, "R3 first order code");
            sum += int'(code_out);
        end
        check("R4 first order sum", sum, NAVG * 300 + 12345);

        // R6: second-order average, switch cycle gives plain integer
        cycle(600, 777, 1, "R8 switch code is integer");
        check("R8 switch value", int'(code_out), 600);
        sum = 0;
        for (int i = 0; i < NAVG; i++) begin
            cycle(600, 777, 1, "R5 second order code");
            sum += int'(code_out);
        end
        n_checks++;
        if (sum - (NAVG * 600 + 777) > 1 || sum - (NAVG * 600 + 777) < -1) begin
            n_fail++;
            $display("FAIL R6 second order sum: actual %0d expected %0d +/-1", sum, NAVG * 600 + 777);
        end

        // R9: clamping at both edges, in both orders
        for (int i = 0; i < 40; i++) cycle(0, 30000, 1, "R9 low edge second");
        for (int i = 0; i < 40; i++) cycle(1023, 32767, 1, "R9 high edge second");
        for (int i = 0; i < 40; i++) cycle(1023, 20000, 0, "R9 high edge first");
        check("R9 top code", int'(code_out), 1023);

        // R7 / R8 / R3 / R5: random traffic with order flips over live residues
        for (int i = 0; i < 6000; i++) begin
            ip = (i % 97 == 0) ? ((i % 2 == 0) ? 0 : 1023) : int'($urandom_range(0, 1023));
            fr = int'($urandom_range(0, FMASK));
            ord = (($urandom_range(0, 31) == 0) ? (m_ord ^ 1) : m_ord);
            cycle(ip, fr, ord, (ord == 1) ? "R7 random second" : "R7 random first");
        end

        // R1: reset in mid-run clears everything back to first order
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        check("R1 mid-run reset", int'(code_out), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) cycle(10, 16384, 0, "R3 after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule